// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller spends bus time on auto-refresh. A divider on the controller clock earns one refresh credit per average refresh interval. A saturating debt register holds the credits that have not yet been spent. While the main command arbiter has other work, the scheduler postpones refresh and lets the debt grow. Once the debt reaches its ceiling, it raises an urgent request that the arbiter must honour ahead of all other traffic.

After a grant, the scheduler owns the command slot. It emits refresh commands back to back, one every refresh cycle time, until the debt is empty or the per-burst ceiling is reached. It then drops its ownership flag so the arbiter can take the bus back. With a 64 ms retention window and 4096 rows, the average interval is about 15.6 µs. The divider is a parameter so that each clock grade gets its own cycle count, for example 1560 cycles at 100 MHz or 2230 at 143 MHz.

Top module: `sdram_refresh_planner`

## Requirements
- R1: While reset is high, and in the cycle after it, rf_req, rf_urgent, rf_cmd and rf_active are all low.
- R2: The scheduler earns one credit every TICK_CYCLES clocks. The first credit lands on the TICK_CYCLES-th rising edge after reset is released, so with an idle arbiter rf_req is low after edge TICK_CYCLES-1 and high after edge TICK_CYCLES.
- R3: rf_req is high exactly when the scheduler is idle, the debt is at least one and arb_busy is low. A high arb_busy holds rf_req low.
- R4: rf_urgent is high exactly when the scheduler is idle and the debt equals DEBT_MAX, whatever arb_busy is. With the arbiter busy from reset, it rises on edge DEBT_MAX*TICK_CYCLES and not before.
- R5: The debt never exceeds DEBT_MAX. Credits earned while the debt is full are dropped, so one grant after a long busy period yields exactly DEBT_MAX commands.
- R6: Within a burst, consecutive rf_cmd pulses are exactly TRFC_CYCLES clocks apart. Each pulse lasts one cycle and lowers the debt by one.
- R7: When rf_grant is high during a cycle in which rf_req or rf_urgent is high, rf_active rises and rf_cmd pulses on the next edge. The burst continues while debt remains, up to DEBT_MAX commands. rf_active then falls TRFC_CYCLES clocks after the last command.
- R8: rf_grant has no effect while neither rf_req nor rf_urgent is high: no rf_cmd pulses and rf_active stays low.
- R9: Any two rf_cmd pulses, including pulses from different bursts, are at least TRFC_CYCLES clocks apart.
- R10: With an arbiter that grants every raised request in the same cycle, the number of credits earned since reset never exceeds the number of commands issued by more than DEBT_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_busy | input | 1 | Arbiter has other commands pending; postpones non-urgent refresh |
| rf_grant | input | 1 | Arbiter hands the command slot to the scheduler |
| rf_req | output | 1 | Ordinary refresh request |
| rf_urgent | output | 1 | Refresh debt is full; must be granted ahead of other traffic |
| rf_cmd | output | 1 | One-cycle pulse: issue one auto-refresh command now |
| rf_active | output | 1 | Scheduler owns the command slot (burst in progress) |

## Verification
The bound checker watches the per-cycle invariants on every clock: the debt ceiling, the spacing of at least TRFC_CYCLES between commands, the per-burst command limit, busy suppressing ordinary requests, a full debt raising urgency, and each credit and command moving the debt by exactly one. Only the bench's scenarios can show the cycle on which the first credit and the urgent request appear. The same holds for the exact command count of a drained burst, credits being dropped once the debt is full, grants being ignored when nothing was asked, and the long-run credit-versus-command lag under an arbiter with a busy pattern.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Phase of the issue sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } rf_phase_e;

    // Request pair presented to the command arbiter.
    typedef struct packed {
        logic normal;
        logic urgent;
    } rf_ask_t;

    // Next debt value: spend first, then add a credit, saturating at cap.
    function automatic int unsigned debt_next(
        input int unsigned cur,
        input logic        credit,
        input logic        spend,
        input int unsigned cap
    );
        int unsigned v;
        v = cur;
        if (spend && v != 0) v = v - 1;
        if (credit && v < cap) v = v + 1;
        return v;
    endfunction

endpackage

// File: rtl/rfsh_interval_tick.sv
module rfsh_interval_tick #(
    parameter int TICK_CYCLES = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic credit
);
    localparam int TW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    assign credit = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (credit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr
    import rfsh_pkg::*;
#(
    parameter int DEBT_MAX = 8,
    parameter int DW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          credit,
    input  logic          spend,
    output logic [DW-1:0] debt,
    output logic          owed,
    output logic          full
);
    logic [DW-1:0] debt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
        end else begin
            debt_q <= DW'(debt_next(32'(debt_q), credit, spend, DEBT_MAX));
        end
    end

    assign debt = debt_q;
    assign owed = (debt_q != '0);
    assign full = (debt_q == DW'(DEBT_MAX));
endmodule

// File: rtl/rfsh_issue_fsm.sv
module rfsh_issue_fsm
    import rfsh_pkg::*;
#(
    parameter int TRFC_CYCLES = 10,
    parameter int DEBT_MAX    = 8,
    parameter int DW          = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    owed,
    input  logic    full,
    input  logic    arb_busy,
    input  logic    grant,
    output rf_ask_t ask,
    output logic    cmd,
    output logic    active
);
    localparam int WW = $clog2(TRFC_CYCLES + 1);
    localparam logic [WW-1:0] WAIT_LOAD = WW'(TRFC_CYCLES - 1);
    localparam logic [DW-1:0] BURST_CAP = DW'(DEBT_MAX);

    rf_phase_e     ph_q, ph_d;
    logic [WW-1:0] wait_q;
    logic [DW-1:0] burst_q;
    logic          idle, start, more, wait_end;

    assign idle       = (ph_q == PH_IDLE);
    assign ask.urgent = idle && full;
    assign ask.normal = idle && owed && !arb_busy;
    assign start      = (ask.normal || ask.urgent) && grant;
    assign more       = owed && (burst_q < BURST_CAP);
    assign wait_end   = (wait_q == WW'(1));

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start) ph_d = PH_ISSUE;
            PH_ISSUE: ph_d = PH_WAIT;
            PH_WAIT:  if (wait_end) ph_d = more ? PH_ISSUE : PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            wait_q  <= '0;
            burst_q <= '0;
        end else begin
            ph_q <= ph_d;
            if (ph_q == PH_ISSUE) begin
                wait_q <= WAIT_LOAD;
            end else if (ph_q == PH_WAIT && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
            if (idle) begin
                burst_q <= '0;
            end else if (ph_q == PH_ISSUE) begin
                burst_q <= burst_q + 1'b1;
            end
        end
    end

    assign cmd    = (ph_q == PH_ISSUE);
    assign active = !idle;
endmodule

// File: rtl/sdram_refresh_planner.sv
module sdram_refresh_planner
    import rfsh_pkg::*;
#(
    parameter int TICK_CYCLES = 1560,
    parameter int TRFC_CYCLES = 10,
    parameter int DEBT_MAX    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_busy,
    input  logic rf_grant,
    output logic rf_req,
    output logic rf_urgent,
    output logic rf_cmd,
    output logic rf_active
);
    localparam int DW = $clog2(DEBT_MAX + 1);

    logic          credit;
    logic [DW-1:0] debt_q;
    logic          owed, full;
    rf_ask_t       ask;

    rfsh_interval_tick #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .credit(credit)
    );

    rfsh_debt_ctr #(
        .DEBT_MAX(DEBT_MAX),
        .DW      (DW)
    ) u_debt (
        .clk   (clk),
        .rst   (rst),
        .credit(credit),
        .spend (rf_cmd),
        .debt  (debt_q),
        .owed  (owed),
        .full  (full)
    );

    rfsh_issue_fsm #(
        .TRFC_CYCLES(TRFC_CYCLES),
        .DEBT_MAX   (DEBT_MAX),
        .DW         (DW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .owed    (owed),
        .full    (full),
        .arb_busy(arb_busy),
        .grant   (rf_grant),
        .ask     (ask),
        .cmd     (rf_cmd),
        .active  (rf_active)
    );

    assign rf_req    = ask.normal;
    assign rf_urgent = ask.urgent;
endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
    parameter int TRFC_CYCLES = 10,
    parameter int DEBT_MAX    = 8,
    parameter int DW          = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          arb_busy,
    input logic          rf_req,
    input logic          rf_urgent,
    input logic          rf_cmd,
    input logic          rf_active,
    input logic          credit,
    input logic [DW-1:0] debt
);
    localparam int GW = $clog2(TRFC_CYCLES + 1);
    localparam int NW = $clog2(DEBT_MAX + 1);

    logic [GW-1:0] gap_q;
    logic [NW-1:0] nb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(TRFC_CYCLES);
            nb_q  <= '0;
        end else begin
            if (rf_cmd) gap_q <= GW'(1);
            else if (gap_q < GW'(TRFC_CYCLES)) gap_q <= gap_q + 1'b1;
            if (!rf_active) nb_q <= '0;
            else if (rf_cmd) nb_q <= nb_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rf_cmd && !rf_active && !rf_req && !rf_urgent));

    assert_credit_adds_R2: assert property (@(posedge clk) disable iff (rst)
        (credit && !rf_cmd && debt < DW'(DEBT_MAX)) |=> debt == $past(debt) + 1'b1);

    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        arb_busy |-> !rf_req);

    assert_full_urgent_R4: assert property (@(posedge clk) disable iff (rst)
        (debt == DW'(DEBT_MAX) && !rf_active) |-> rf_urgent);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        debt <= DW'(DEBT_MAX));

    assert_cmd_spends_R6: assert property (@(posedge clk) disable iff (rst)
        (rf_cmd && !credit) |=> debt == $past(debt) - 1'b1);

    assert_burst_limit_R7: assert property (@(posedge clk) disable iff (rst)
        rf_cmd |-> (rf_active && nb_q < NW'(DEBT_MAX)));

    assert_cmd_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        rf_cmd |-> gap_q >= GW'(TRFC_CYCLES));
endmodule

bind sdram_refresh_planner rfsh_checker #(
    .TRFC_CYCLES(TRFC_CYCLES),
    .DEBT_MAX   (DEBT_MAX),
    .DW         (DW)
) u_rfsh_checker (
    .clk      (clk),
    .rst      (rst),
    .arb_busy (arb_busy),
    .rf_req   (rf_req),
    .rf_urgent(rf_urgent),
    .rf_cmd   (rf_cmd),
    .rf_active(rf_active),
    .credit   (credit),
    .debt     (debt_q)
);

// File: tb/test_sdram_refresh_planner.sv
module test_sdram_refresh_planner;
    localparam int TICK = 40;
    localparam int TRFC = 5;
    localparam int DMAX = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arb_busy = 1'b0;
    logic rf_grant = 1'b0;
    logic rf_req, rf_urgent, rf_cmd, rf_active;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Monitor state (reset by do_reset)
    int edges = 0;
    int cmd_total = 0;
    int last_edge = 0;
    int min_gap = 1000000;
    int max_lag = 0;

    always #2 clk = ~clk;

    sdram_refresh_planner #(
        .TICK_CYCLES(TICK),
        .TRFC_CYCLES(TRFC),
        .DEBT_MAX   (DMAX)
    ) i_sdram_refresh_planner (
        .clk      (clk),
        .rst      (rst),
        .arb_busy (arb_busy),
        .rf_grant (rf_grant),
        .rf_req   (rf_req),
        .rf_urgent(rf_urgent),
        .rf_cmd   (rf_cmd),
        .rf_active(rf_active)
    );

    always @(posedge clk) begin
        if (rst) edges = 0;
        else edges = edges + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rf_cmd) begin
                if (cmd_total > 0 && edges - last_edge < min_gap) min_gap = edges - last_edge;
                last_edge = edges;
                cmd_total = cmd_total + 1;
            end
            if (edges / TICK - cmd_total > max_lag) max_lag = edges / TICK - cmd_total;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        arb_busy = 1'b0;
        rf_grant = 1'b0;
        step(2);
        cmd_total = 0;
        min_gap = 1000000;
        max_lag = 0;
        step(1);
        rst = 1'b0;
    endtask

    task automatic serve_burst(output int n, output int gmin, output int gmax);
        int t;
        int last;
        int tries;
        t = 0; last = -1; tries = 0;
        n = 0; gmin = 1000000; gmax = 0;
        rf_grant = 1'b1;
        while (!rf_active && tries < 50) begin
            step(1); t++; tries++;
        end
        while (rf_active && t < 2000) begin
            if (rf_cmd) begin
                if (last >= 0) begin
                    if (t - last < gmin) gmin = t - last;
                    if (t - last > gmax) gmax = t - last;
                end
                last = t;
                n++;
            end
            step(1); t++;
        end
        rf_grant = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(3);
        check(!rf_req && !rf_urgent && !rf_cmd && !rf_active, "R1 during reset",
              {rf_req, rf_urgent, rf_cmd, rf_active}, 0);
        rst = 1'b0;
        step(1);
        check(!rf_req && !rf_urgent && !rf_cmd && !rf_active, "R1 after reset",
              {rf_req, rf_urgent, rf_cmd, rf_active}, 0);
    endtask

    task automatic t_first_credit();
        int n, gmin, gmax;
        do_reset();
        step(TICK - 1);
        check(!rf_req, "R2 no request before first interval", rf_req, 0);
        step(1);
        check(rf_req, "R2 request at first interval", rf_req, 1);
        arb_busy = 1'b1;
        step(1);
        check(!rf_req, "R3 busy holds request low", rf_req, 0);
        check(!rf_urgent, "R4 no urgency with debt one", rf_urgent, 0);
        arb_busy = 1'b0;
        step(1);
        check(rf_req, "R3 request back when idle", rf_req, 1);
        serve_burst(n, gmin, gmax);
        check(n == 1, "R7 single-credit burst", n, 1);
        check(!rf_active && !rf_req, "R7 released and debt drained",
              {rf_active, rf_req}, 0);
    endtask

    task automatic t_grant_ignored();
        int seen;
        seen = 0;
        rf_grant = 1'b1;
        repeat (10) begin
            step(1);
            if (rf_cmd || rf_active) seen++;
        end
        rf_grant = 1'b0;
        check(seen == 0, "R8 grant without request ignored", seen, 0);
    endtask

    task automatic t_postpone();
        int n, gmin, gmax, seen;
        do_reset();
        arb_busy = 1'b1;
        step(3 * TICK);
        check(!rf_req && !rf_urgent, "R3 postponed while busy", {rf_req, rf_urgent}, 0);
        seen = 0;
        rf_grant = 1'b1;
        repeat (5) begin
            step(1);
            if (rf_active || rf_cmd) seen++;
        end
        rf_grant = 1'b0;
        check(seen == 0, "R8 grant ignored while busy below limit", seen, 0);
        arb_busy = 1'b0;
        step(1);
        check(rf_req, "R3 request after busy ends", rf_req, 1);
        serve_burst(n, gmin, gmax);
        check(n == 3, "R7 burst drains three credits", n, 3);
        check(gmin == TRFC, "R6 min in-burst spacing", gmin, TRFC);
        check(gmax == TRFC, "R6 max in-burst spacing", gmax, TRFC);
    endtask

    task automatic t_urgent();
        int n, gmin, gmax;
        do_reset();
        arb_busy = 1'b1;
        step(DMAX * TICK - 1);
        check(!rf_urgent, "R4 not urgent one cycle early", rf_urgent, 0);
        step(1);
        check(rf_urgent, "R4 urgent at debt limit", rf_urgent, 1);
        step(3 * TICK);
        check(rf_urgent && !rf_req, "R4 urgent persists, busy blocks normal",
              {rf_urgent, rf_req}, 2);
        serve_burst(n, gmin, gmax);
        check(n == DMAX, "R5 saturated debt gives limit commands", n, DMAX);
        check(gmin == TRFC && gmax == TRFC, "R6 urgent burst spacing", gmin, TRFC);
        check(!rf_urgent && !rf_active, "R4 urgency cleared after burst",
              {rf_urgent, rf_active}, 0);
    endtask

    task automatic t_lag();
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        do_reset();
        repeat (30 * TICK) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            arb_busy = (lfsr[2:0] != 3'd0);
            #1;
            rf_grant = rf_urgent | rf_req;
            step(1);
        end
        rf_grant = 1'b0;
        arb_busy = 1'b0;
        check(max_lag <= DMAX, "R10 credit lag bounded", max_lag, DMAX);
        check(min_gap >= TRFC, "R9 spacing across bursts", min_gap, TRFC);
        check(cmd_total >= 30 - DMAX, "R10 refreshes keep pace", cmd_total, 30 - DMAX);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_first_credit();
        t_grant_ignored();
        t_postpone();
        t_urgent();
        t_lag();
        finish_run();
    end
endmodule